// File: doc/BRIEF.md
# Ethernet destination address filter

This block decides whether an incoming frame should be kept, looking only at its 48-bit destination address. The address arrives one bit per qualified clock, least significant bit first, following a start-of-frame pulse. The first address bit tells individual addresses (0) from group addresses (1).

An individual address is kept only if all 48 bits equal a programmed station address. The station address is held in six byte registers. For a group address, a running CRC-32 is computed over the 48 address bits. Its six top bits pick one of 64 bits in a filter mask held in eight byte registers, and that bit alone decides whether the frame is kept.

The decision appears one clock after the last address bit and is held until the next start of frame. Software programs the registers through a simple byte write port.

Top module: `da_filter`

## Requirements
- R1: After reset, `done`, `accept` and `reject` are 0, and all station and filter registers are zero.
- R2: A write with `wr_en` high stores `wr_data` into the register that `wr_addr` selects. Values 0..5 select station bytes 0..5. Values 8..15 select filter bytes 0..7. Values 6 and 7 change nothing.
- R3: The k-th qualified bit after `sof` (k = 0..47) is address bit k. It is compared with bit k%8 of station byte k/8. A cycle with `bit_vld` low does not advance the bit count.
- R4: When address bit 0 is 0, the frame is accepted if and only if all 48 address bits equal the station registers.
- R5: When address bit 0 is 1, the decision depends only on the selected filter bit. The frame is accepted if that bit is 1 and rejected if it is 0, whatever the station registers hold.
- R6: The CRC is preset to all ones. For each address bit d, with f = d XOR crc[31], the CRC shifts left by one and is XORed with 0x04C11DB7 when f is 1. After bit 47, the index n = crc[31:26] (crc[31] is the MSB) selects filter bit n, which is bit n%8 of filter byte n/8.
- R7: `done` rises at the clock edge that samples the 48th qualified bit. `accept` and `reject` become valid at that same edge. All three then hold, even across register writes, until the next `sof`.
- R8: A `sof` cycle clears `done`, `accept` and `reject` at that edge and restarts the bit count. `bit_vld` is ignored during a `sof` cycle.
- R9: Qualified bits after the 48th, and bits before the first `sof`, have no effect.
- R10: `reject` is high exactly when `done` is high and `accept` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; restarts address capture |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial destination address bit, LSB first |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select |
| wr_data | input | 8 | Register write data |
| done | output | 1 | Decision valid |
| accept | output | 1 | Frame kept |
| reject | output | 1 | Frame dropped |

## Verification
The bench builds the block with its default parameters: CRC polynomial 0x04C11DB7 and all-ones preset. With these values its own arithmetic model of the hash matches the design bit for bit.

For each of the 64 filter-bit indices, the bench searches for a group address that hashes to that index. It then checks acceptance with only that bit set and rejection with every other bit set, which covers the whole decode.

For individual addresses, it flips each of the 47 compared non-indicator bits of the station address in turn. Further frames cover bit gaps, trailing extra bits, ignored register addresses and writes made after a decision.

// File: rtl/da_filter.sv
module da_filter #(
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       done,
  output logic       accept,
  output logic       reject
);
  localparam int DA_BITS = 48;
  localparam int CNT_W   = $clog2(DA_BITS + 1);
  localparam int HASH_W  = 6;
  localparam int NSTA    = DA_BITS / 8;

  logic [DA_BITS-1:0]      sta;
  logic [(1<<HASH_W)-1:0]  mask;
  logic [CNT_W-1:0]        cnt;
  logic [31:0]             crc;
  logic                    match, mcast;

  wire              take      = bit_vld && !sof && (cnt < CNT_W'(DA_BITS));
  wire              last      = take && (cnt == CNT_W'(DA_BITS - 1));
  wire              sta_bit   = sta[cnt];
  wire [31:0]       crc_nxt   = {crc[30:0], 1'b0} ^ ((bit_in ^ crc[31]) ? CRC_POLY : 32'h0);
  wire              match_nxt = match && (bit_in == sta_bit);
  wire [HASH_W-1:0] hash      = crc_nxt[31:32-HASH_W];

  assign reject = done && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta  <= '0;
      mask <= '0;
    end else if (wr_en) begin
      if (wr_addr[3])
        mask[{wr_addr[2:0], 3'b000} +: 8] <= wr_data;
      else
        for (int i = 0; i < NSTA; i++)
          if (wr_addr[2:0] == 3'(i)) sta[i*8 +: 8] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= CNT_W'(DA_BITS);
      crc    <= CRC_INIT;
      match  <= 1'b0;
      mcast  <= 1'b0;
      done   <= 1'b0;
      accept <= 1'b0;
    end else if (sof) begin
      cnt    <= '0;
      crc    <= CRC_INIT;
      match  <= 1'b1;
      mcast  <= 1'b0;
      done   <= 1'b0;
      accept <= 1'b0;
    end else if (take) begin
      cnt   <= cnt + 1'b1;
      crc   <= crc_nxt;
      match <= match_nxt;
      if (cnt == '0) mcast <= bit_in;
      if (last) begin
        done   <= 1'b1;
        accept <= mcast ? mask[hash] : match_nxt;
      end
    end
  end
endmodule

// File: rtl/da_filter_chk.sv
module da_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic sof,
  input logic wr_en,
  input logic done,
  input logic accept,
  input logic reject
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !done && !accept); // R1
  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sof |=> !done && !accept); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) done && !sof |=> done); // R7
  AST_DECISION_STABLE: assert property (@(posedge clk) disable iff (!rst_n) done && !sof |=> $stable(accept)); // R7
  AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) accept |-> done); // R10
  AST_REJECT_FORM: assert property (@(posedge clk) disable iff (!rst_n) reject |-> done && !accept); // R10
  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) wr_en && done && !sof |=> $stable(accept)); // R7
endmodule

bind da_filter da_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .wr_en(wr_en),
  .done(done), .accept(accept), .reject(reject)
);

// File: tb/da_filter_tb.sv
module da_filter_tb;
  logic clk = 0, rst_n = 0, sof = 0, bit_vld = 0, bit_in = 0, wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic done, accept, reject;
  int n_cmp = 0, n_bad = 0;
  logic [63:0] rng = 64'h1234_5678_9ABC_DEF1;

  always #2.5 clk = ~clk;

  da_filter u_dut (.clk, .rst_n, .sof, .bit_vld, .bit_in, .wr_en, .wr_addr, .wr_data,
                   .done, .accept, .reject);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hash_of(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic f = da[i] ^ c[31];
      c = c << 1;
      if (f) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [47:0] next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng[47:0];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_station(input logic [47:0] s);
    for (int i = 0; i < 6; i++) wr(4'(i), s[i*8 +: 8]);
  endtask

  task automatic set_mask(input logic [63:0] m);
    for (int i = 0; i < 8; i++) wr(4'(8 + i), m[i*8 +: 8]);
  endtask

  // sends sof then 48 bits; samples one edge after the last bit
  task automatic frame(input logic [47:0] da, input bit gaps, input bit exp_acc, input string req);
    @(negedge clk); sof = 1; bit_vld = 1; bit_in = ~da[0];
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i == 0) chk(done, 0, "R8 done cleared by sof");
      sof = 0;
      if (gaps && (i % 5 == 2)) begin
        bit_vld = 0; bit_in = ~da[i];
        @(negedge clk);
      end
      bit_vld = 1; bit_in = da[i];
    end
    @(negedge clk); bit_vld = 0;
    chk(done, 1, "R7 done after 48th bit");
    chk(accept, exp_acc, req);
    chk(reject, !exp_acc, "R10 reject");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] st, da;
    repeat (3) @(negedge clk);
    chk({done, accept, reject}, 0, "R1 reset outputs");
    rst_n = 1;
    // R9: bits before any sof do nothing
    @(negedge clk); bit_vld = 1; bit_in = 1;
    repeat (60) @(negedge clk);
    bit_vld = 0;
    chk(done, 0, "R9 no decision without sof");
    // R1: zeroed station matches all-zero individual address
    frame(48'h0, 0, 1, "R1 registers reset to zero");

    st = 48'hA5C3_1E72_9B40;
    set_station(st);
    frame(st, 0, 1, "R4 exact match accepted");
    frame(st, 1, 1, "R3 gaps in bit_vld");
    for (int k = 1; k < 48; k++) begin
      da = st; da[k] = ~da[k];
      frame(da, k[0], 0, "R4 single-bit mismatch rejected");
    end
    wr(4'd6, 8'hFF); wr(4'd7, 8'h5A);
    frame(st, 0, 1, "R2 addresses 6 and 7 ignored");
    // R9 trailing bits ignored; R7 held across writes
    @(negedge clk); bit_vld = 1; bit_in = 1;
    repeat (10) @(negedge clk);
    bit_vld = 0;
    chk(accept, 1, "R9 trailing bits ignored");
    wr(4'd0, 8'h00);
    chk(accept, 1, "R7 held across station write");
    frame(st, 0, 0, "R2 station byte 0 rewritten");
    wr(4'd0, st[7:0]);

    // R5/R6: every filter index
    for (int n = 0; n < 64; n++) begin
      do begin
        da = next_rng(); da[0] = 1'b1;
      end while (hash_of(da) != 6'(n));
      set_mask(64'd1 << n);
      frame(da, 0, 1, "R6 selected filter bit set");
      set_mask(~(64'd1 << n));
      frame(da, 0, 0, "R6 selected filter bit clear");
    end
    // R5: station match irrelevant for group address
    st[0] = 1'b1;
    set_station(st);
    set_mask(64'd0);
    frame(st, 0, 0, "R5 group address ignores station");
    for (int j = 0; j < 40; j++) begin
      logic [63:0] m;
      m = {next_rng(), 16'h0} ^ {16'h0, next_rng()};
      set_mask(m);
      da = next_rng(); da[0] = 1'b1;
      frame(da, j[0], m[hash_of(da)], "R5 random mask");
    end
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    chk({done, accept, reject}, 0, "R8 sof clears decision");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule